// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models a serial EEPROM target that holds 1024 words of 16 bits behind a chip select, a serial clock, a data input and a data output. The data output has a separate output-enable that stands in for a tri-state pin. The block runs on a fast system clock. It passes the three serial inputs through a synchronizer and acts on the edges it detects in them.

A host selects the part and clocks in an instruction. The instruction is a start bit, an operation field and a word address. The target then does one of four things: it streams words out for a read, takes in one word for a write, sets or clears its write-enable latch, or discards a fill-all request. A write is programmed over a self-timed period that lasts a fixed number of system clocks. During that period the data output serves as a busy/ready flag.

Top module: `serial_eeprom_target`

## Requirements
- R1: An instruction begins at the first 1 sampled on DI while CS is high. Zeros clocked in before that 1 are ignored. After the start bit come a 2-bit operation code and a 10-bit address, both MSB first.
- R2: The operation codes are: 10 reads, 01 writes, and 00 is a system command selected by address bits [9:8]. For a system command, 11 sets the write-enable latch, 00 clears it, and 01 (fill all words) changes nothing.
- R3: DI is sampled on rising edges of SK. During a read, DO changes value only after an SK rising edge.
- R4: A read drives DO with output-enable high, starting on the SK rise that samples address bit 0. DO first carries a single 0 dummy bit, then the 16 bits of the addressed word, MSB first, one bit per SK rise.
- R5: If SK keeps running after the 16th data bit, the next word follows with no dummy bit. The address after 0x3FF is 0x000.
- R6: The write-enable latch is clear after reset. A write that arrives while the latch is clear changes no word and starts no programming period. Reads work whatever the latch holds.
- R7: A write takes exactly 16 data bits. Programming starts when CS falls after the 16th data bit. If another SK rise comes before that CS fall, the write is cancelled.
- R8: After programming has started, DO shows 0 while CS is high and the word is still being programmed, and 1 once it is done. This status stays on DO until the next start bit is sampled, and output-enable drops on that start bit.
- R9: Output-enable is low whenever CS is low and after reset.
- R10: The programming period lasts PROG_CYCLES system clocks. The word is updated when the period ends.
- R11: If CS falls before an instruction is complete, including a write with fewer than 16 data bits, nothing changes in the array or the latch, and no programming starts.
- R12: While programming is in progress, all clocked-in instructions are ignored, and the status output keeps showing busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sk_i | input | 1 | Serial clock from the host (asynchronous) |
| cs_i | input | 1 | Chip select, active high (asynchronous) |
| di_i | input | 1 | Serial data from the host (asynchronous) |
| do_o | output | 1 | Serial read data or busy/ready status |
| do_oe_o | output | 1 | Output-enable for do_o (tri-state stand-in) |

## Verification
Two events can meet in the same decision window: a CS fall and an SK rise that follows the 16th data bit of a write. The bench provokes this by giving one write a single extra SK pulse right before CS drops, and by ending another write on time. It then reads the word back to judge which write committed. A second overlap is the end of the programming period while a whole instruction is being clocked in. The bench sends a complete write during the busy period and checks three things: the status stays busy until the period ends, the status turns ready afterwards, and the target word is left unchanged.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_RD,
      ST_WDAT,
      ST_WFULL,
      ST_SKIP
   } ctl_state_t;

   localparam logic [1:0] OP_SYS   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;

   localparam logic [1:0] SYS_LOCK   = 2'b00;
   localparam logic [1:0] SYS_FILL   = 2'b01;
   localparam logic [1:0] SYS_UNLOCK = 2'b11;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg <= d_i;
         end
         assign q_o = stg;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[STAGES-2:0], d_i};
         end
         assign q_o = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
   parameter int AW          = 10,
   parameter int DW          = 16,
   parameter int PROG_CYCLES = 600
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   output logic          busy_o,
   output logic          commit_o,
   output logic [AW-1:0] waddr_o,
   output logic [DW-1:0] wdata_o
);

   localparam int CNT_W = $clog2(PROG_CYCLES + 1);

   logic [CNT_W-1:0] remain;
   logic             busy_q;
   logic             commit_q;
   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain   <= '0;
         busy_q   <= 1'b0;
         commit_q <= 1'b0;
         addr_q   <= '0;
         data_q   <= '0;
      end else begin
         commit_q <= 1'b0;
         if (!busy_q && start_i) begin
            busy_q <= 1'b1;
            remain <= CNT_W'(PROG_CYCLES - 1);
            addr_q <= addr_i;
            data_q <= data_i;
         end else if (busy_q) begin
            if (remain == '0) begin
               busy_q   <= 1'b0;
               commit_q <= 1'b1;
            end else begin
               remain <= remain - 1'b1;
            end
         end
      end
   end

   assign busy_o   = busy_q;
   assign commit_o = commit_q;
   assign waddr_o  = addr_q;
   assign wdata_o  = data_q;

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
   import eep_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sk_rise_i,
   input  logic          cs_fall_i,
   input  logic          cs_lvl_i,
   input  logic          di_i,
   input  logic          busy_i,
   input  logic [DW-1:0] rd_word_i,
   output logic [AW-1:0] rd_addr_o,
   output logic          prog_start_o,
   output logic [AW-1:0] prog_addr_o,
   output logic [DW-1:0] prog_data_o,
   output logic          wen_o,
   output logic          status_o,
   output logic          rd_active_o,
   output logic          rd_bit_o
);

   localparam int MAXF = (AW > DW) ? AW : DW;
   localparam int CW   = $clog2(MAXF + 1);
   localparam int BW   = (DW > 1) ? $clog2(DW) : 1;

   ctl_state_t    state;
   logic [CW-1:0] cnt;
   logic [1:0]    op_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [AW-1:0] ptr_q;
   logic [BW-1:0] bit_idx;
   logic          do_q;
   logic          wen_q;
   logic          status_q;
   logic          start_q;

   logic [AW-1:0] addr_nx;
   logic [DW-1:0] data_nx;
   logic [1:0]    sys_sel;

   assign addr_nx = {addr_q[AW-2:0], di_i};
   assign data_nx = {data_q[DW-2:0], di_i};
   assign sys_sel = addr_nx[AW-1 -: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         op_q     <= '0;
         addr_q   <= '0;
         data_q   <= '0;
         ptr_q    <= '0;
         bit_idx  <= '0;
         do_q     <= 1'b0;
         wen_q    <= 1'b0;
         status_q <= 1'b0;
         start_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (cs_fall_i) begin
            state <= ST_IDLE;
            if (state == ST_WFULL && wen_q && !busy_i) begin
               start_q  <= 1'b1;
               status_q <= 1'b1;
            end
         end else if (sk_rise_i && cs_lvl_i) begin
            unique case (state)
               ST_IDLE: begin
                  if (di_i && !busy_i) begin
                     status_q <= 1'b0;
                     cnt      <= '0;
                     state    <= ST_OPC;
                  end
               end
               ST_OPC: begin
                  op_q <= {op_q[0], di_i};
                  if (cnt == CW'(1)) begin
                     cnt   <= '0;
                     state <= ST_ADR;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ADR: begin
                  addr_q <= addr_nx;
                  if (cnt == CW'(AW - 1)) begin
                     cnt <= '0;
                     unique case (op_q)
                        OP_READ: begin
                           ptr_q   <= addr_nx;
                           bit_idx <= BW'(DW - 1);
                           do_q    <= 1'b0;
                           state   <= ST_RD;
                        end
                        OP_WRITE: begin
                           state <= ST_WDAT;
                        end
                        OP_SYS: begin
                           if (sys_sel == SYS_UNLOCK)    wen_q <= 1'b1;
                           else if (sys_sel == SYS_LOCK) wen_q <= 1'b0;
                           state <= ST_SKIP;
                        end
                        default: state <= ST_SKIP;
                     endcase
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_RD: begin
                  do_q <= rd_word_i[bit_idx];
                  if (bit_idx == '0) begin
                     bit_idx <= BW'(DW - 1);
                     ptr_q   <= ptr_q + 1'b1;
                  end else begin
                     bit_idx <= bit_idx - 1'b1;
                  end
               end
               ST_WDAT: begin
                  data_q <= data_nx;
                  if (cnt == CW'(DW - 1)) begin
                     cnt   <= '0;
                     state <= ST_WFULL;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_WFULL: state <= ST_SKIP;
               ST_SKIP:  state <= ST_SKIP;
               default:  state <= ST_IDLE;
            endcase
         end
      end
   end

   assign rd_addr_o    = ptr_q;
   assign prog_start_o = start_q;
   assign prog_addr_o  = addr_q;
   assign prog_data_o  = data_q;
   assign wen_o        = wen_q;
   assign status_o     = status_q;
   assign rd_active_o  = (state == ST_RD);
   assign rd_bit_o     = do_q;

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
   import eep_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 16,
   parameter int PROG_CYCLES = 600,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sk_i,
   input  logic cs_i,
   input  logic di_i,
   output logic do_o,
   output logic do_oe_o
);

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 12)
         else $error("ADDR_W must lie in 2..12");
      assert (DATA_W >= 2)
         else $error("DATA_W must be at least 2");
      assert (PROG_CYCLES >= 1)
         else $error("PROG_CYCLES must be at least 1");
      assert (SYNC_STAGES >= 1)
         else $error("SYNC_STAGES must be at least 1");
   end

   logic [2:0]        pins_s;
   logic              sk_s, cs_s, di_s;
   logic              sk_d, cs_d;
   logic              sk_rise, cs_fall;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_word;
   logic              prog_start;
   logic [ADDR_W-1:0] prog_addr;
   logic [DATA_W-1:0] prog_data;
   logic              wen;
   logic              status;
   logic              rd_active;
   logic              rd_bit;
   logic              busy;
   logic              commit;
   logic [ADDR_W-1:0] waddr;
   logic [DATA_W-1:0] wdata;

   eep_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sk_i, cs_i, di_i}),
      .q_o   (pins_s)
   );

   assign sk_s = pins_s[2];
   assign cs_s = pins_s[1];
   assign di_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sk_d <= 1'b0;
         cs_d <= 1'b0;
      end else begin
         sk_d <= sk_s;
         cs_d <= cs_s;
      end
   end

   assign sk_rise = sk_s & ~sk_d;
   assign cs_fall = ~cs_s & cs_d;

   eep_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sk_rise_i    (sk_rise),
      .cs_fall_i    (cs_fall),
      .cs_lvl_i     (cs_s),
      .di_i         (di_s),
      .busy_i       (busy),
      .rd_word_i    (rd_word),
      .rd_addr_o    (rd_addr),
      .prog_start_o (prog_start),
      .prog_addr_o  (prog_addr),
      .prog_data_o  (prog_data),
      .wen_o        (wen),
      .status_o     (status),
      .rd_active_o  (rd_active),
      .rd_bit_o     (rd_bit)
   );

   eep_prog_timer #(.AW(ADDR_W), .DW(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (prog_start),
      .addr_i   (prog_addr),
      .data_i   (prog_data),
      .busy_o   (busy),
      .commit_o (commit),
      .waddr_o  (waddr),
      .wdata_o  (wdata)
   );

   eep_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
      .clk     (clk),
      .we_i    (commit),
      .waddr_i (waddr),
      .wdata_i (wdata),
      .raddr_i (rd_addr),
      .rdata_o (rd_word)
   );

   assign do_oe_o = cs_s & (rd_active | status);
   assign do_o    = do_oe_o & (status ? ~busy : rd_bit);

endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
   parameter int PROG_CYCLES = 600
) (
   input logic clk,
   input logic rst_n,
   input logic cs_lvl,
   input logic sk_rise,
   input logic rd_active,
   input logic busy,
   input logic wen,
   input logic do_o,
   input logic do_oe_o
);

   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   a_r9_oe_off_when_deselected: assert property (
      @(posedge clk) disable iff (!rst_n) !cs_lvl |-> !do_oe_o);

   a_r8_busy_shows_zero: assert property (
      @(posedge clk) disable iff (!rst_n) (busy && do_oe_o) |-> !do_o);

   a_r3_do_moves_only_on_sk: assert property (
      @(posedge clk) disable iff (!rst_n)
      (rd_active && $past(rd_active) && cs_lvl && $past(cs_lvl) && !$past(sk_rise))
      |-> $stable(do_o));

   a_r6_prog_needs_enable: assert property (
      @(posedge clk) disable iff (!rst_n) $rose(busy) |-> wen);

   a_r12_latch_frozen_while_busy: assert property (
      @(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(wen));

   a_r10_busy_within_period: assert property (
      @(posedge clk) disable iff (!rst_n) busy |-> (busy_len < PROG_CYCLES));

   a_r10_busy_full_period: assert property (
      @(posedge clk) disable iff (!rst_n) $fell(busy) |-> (busy_len == PROG_CYCLES));

endmodule

bind serial_eeprom_target eep_checker #(.PROG_CYCLES(PROG_CYCLES)) u_eep_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_lvl    (cs_s),
   .sk_rise   (sk_rise),
   .rd_active (rd_active),
   .busy      (busy),
   .wen       (wen),
   .do_o      (do_o),
   .do_oe_o   (do_oe_o)
);

// File: tb/tb_serial_eeprom_target.sv
module tb_serial_eeprom_target;

   localparam int PROG = 600;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sk = 1'b0;
   logic cs = 1'b0;
   logic di = 1'b0;
   logic do_w;
   logic oe_w;

   always #2 clk = ~clk;

   serial_eeprom_target #(.PROG_CYCLES(PROG)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .sk_i    (sk),
      .cs_i    (cs),
      .di_i    (di),
      .do_o    (do_w),
      .do_oe_o (oe_w)
   );

   int nchk = 0;
   int nerr = 0;
   logic [15:0] mem_m [1024];
   logic wen_m = 1'b0;
   int cs_low_cnt = 0;

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
   endtask

   // R9 on every clock: output-enable must be off once CS has been low a while
   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs) cs_low_cnt++;
         else     cs_low_cnt = 0;
         if (cs_low_cnt > 4) begin
            nchk++;
            if (oe_w !== 1'b0) begin
               nerr++;
               $display("FAIL R9 oe while CS low: actual=%0b expected=0", oe_w);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clk_bit(input logic b, output logic pre, output logic dv, output logic ov);
      di = b;
      tick(HALF);
      pre = do_w;
      sk = 1'b1;
      tick(HALF);
      dv = do_w;
      ov = oe_w;
      sk = 1'b0;
   endtask

   task automatic send(logic [31:0] v, int n);
      logic a, b, c;
      for (int i = n - 1; i >= 0; i--) clk_bit(v[i], a, b, c);
   endtask

   task automatic cs_up();
      cs = 1'b1;
      tick(2 * HALF);
   endtask

   task automatic cs_dn();
      sk = 1'b0;
      cs = 1'b0;
      tick(2 * HALF);
   endtask

   task automatic sys_cmd(logic [1:0] sel, int lead);
      cs_up();
      send(32'd0, lead);
      send({19'd0, 1'b1, 2'b00, sel, 8'h00}, 13);
      cs_dn();
      if (sel == 2'b11) wen_m = 1'b1;
      if (sel == 2'b00) wen_m = 1'b0;
   endtask

   task automatic write_word(int a, logic [15:0] d, int nb, bit extra);
      logic [9:0] a10;
      a10 = a[9:0];
      cs_up();
      send({19'd0, 1'b1, 2'b01, a10}, 13);
      send({16'd0, d} >> (16 - nb), nb);
      if (extra) send(32'd0, 1);
      cs_dn();
      if (wen_m && nb == 16 && !extra) mem_m[a10] = d;
   endtask

   task automatic poll_ready();
      cs_up();
      chk("R8 busy oe", {31'd0, oe_w}, 1);
      chk("R8 busy value", {31'd0, do_w}, 0);
      tick(PROG - 40);
      chk("R10 still busy near end", {31'd0, do_w}, 0);
      tick(60);
      chk("R10 ready after period", {31'd0, do_w}, 1);
      chk("R8 ready oe", {31'd0, oe_w}, 1);
      send(32'd0, 3);
      chk("R8 status held over zero bits", {31'd0, do_w}, 1);
      cs_dn();
   endtask

   task automatic no_status(string tag);
      cs_up();
      chk(tag, {31'd0, oe_w}, 0);
      cs_dn();
   endtask

   task automatic read_check(int a, int nw, string tag);
      logic pre, dv, ov, prev;
      logic [9:0] a10;
      a10 = a[9:0];
      cs_up();
      clk_bit(1'b1, pre, dv, ov);
      chk("R8 start bit releases DO", {31'd0, ov}, 0);
      send(32'b10, 2);
      send({23'd0, a10[9:1]}, 9);
      clk_bit(a10[0], pre, dv, ov);
      chk("R4 dummy oe", {31'd0, ov}, 1);
      chk("R4 dummy bit", {31'd0, dv}, 0);
      prev = dv;
      for (int w = 0; w < nw; w++) begin
         for (int b = 15; b >= 0; b--) begin
            clk_bit(1'b0, pre, dv, ov);
            chk("R3 DO steady between SK rises", {31'd0, pre}, {31'd0, prev});
            chk(tag, {31'd0, dv}, {31'd0, mem_m[10'(a10 + w)][b]});
            prev = dv;
         end
      end
      cs_dn();
      chk("R9 oe off after deselect", {31'd0, oe_w}, 0);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(3);
      chk("R9 reset oe", {31'd0, oe_w}, 0);
      chk("R9 reset do", {31'd0, do_w}, 0);

      // R6: write while latch clear is dropped
      write_word(10'h005, 16'h9999, 16, 1'b0);
      no_status("R6 no programming while locked");

      // R1/R2: enable with leading zeros
      sys_cmd(2'b11, 3);
      write_word(10'h005, 16'hA5C3, 16, 1'b0);
      poll_ready();
      read_check(10'h005, 1, "R4 read data");

      // R5: sequential read across the wrap point
      write_word(10'h3FF, 16'h1234, 16, 1'b0);
      poll_ready();
      write_word(10'h000, 16'hFEDC, 16, 1'b0);
      poll_ready();
      read_check(10'h3FF, 2, "R5 sequential wrap");

      // R6: disable, then write ignored, read still works
      sys_cmd(2'b00, 0);
      write_word(10'h005, 16'h0000, 16, 1'b0);
      no_status("R6 locked write gives no status");
      read_check(10'h005, 1, "R6 read while locked");

      // R2: fill-all command has no effect
      sys_cmd(2'b11, 0);
      cs_up();
      send({19'd0, 1'b1, 2'b00, 2'b01, 8'h00}, 13);
      send(32'hFFFF, 16);
      cs_dn();
      no_status("R2 fill-all starts nothing");
      read_check(10'h005, 1, "R2 fill-all leaves word");

      // R11: short write aborted
      write_word(10'h005, 16'h3C3C, 10, 1'b0);
      no_status("R11 short write aborted");
      read_check(10'h005, 1, "R11 word unchanged");

      // R7: extra SK rise before CS fall cancels
      write_word(10'h005, 16'h1111, 16, 1'b1);
      no_status("R7 extra clock cancels write");
      read_check(10'h005, 1, "R7 word unchanged");

      // R12: instruction during programming ignored
      write_word(10'h3FF, 16'h5555, 16, 1'b0);
      cs_up();
      chk("R12 busy before foreign frame", {31'd0, do_w}, 0);
      send({19'd0, 1'b1, 2'b01, 10'h000}, 13);
      send(32'h0F0F, 16);
      chk("R12 still busy oe", {31'd0, oe_w}, 1);
      chk("R12 still busy value", {31'd0, do_w}, 0);
      cs_dn();
      cs_up();
      tick(PROG);
      chk("R12 ready after period", {31'd0, do_w}, 1);
      cs_dn();
      read_check(10'h3FF, 2, "R12 target kept, new word written");

      summary();
      $finish;
   end

endmodule